// File: doc/BRIEF.md
# Flash Current Ramp Controller with Battery Droop Limit

This block produces the digital LED current setpoint for each channel of a camera flash driver during a strobe. While a strobe is requested, each channel's level climbs slowly toward its programmed target, in units of 25 mA. When the request ends, every level falls quickly to zero. A single-cycle completion pulse follows once all levels are zero.

The controller guards against battery collapse. In the cycle a strobe starts, it records the battery reading minus a selectable droop allowance as a floor. It compares the battery with that floor on every microsecond tick. If the battery goes below the floor, upward steps stop for the rest of the strobe and each level stays where it is. A blanking input lowers every channel's target to a shared video-light code and suspends the droop comparison while it is high.

One channel is the wide channel, with a higher ceiling and a wider target code. The other channels share a narrower code. The analog comparator, the battery sampling and the current sinks belong to the surrounding logic.

Top module: `flash_ramp_ctrl`

## Requirements
- R1: While reset is held, every channel level is 0 and the completion pulse is low.
- R2: A level counts 25 mA per unit. The wide channel (index 1) takes a 6-bit target code clamped at 32 (800 mA). The other channels take a shared 5-bit code clamped at 16 (400 mA).
- R3: While a strobe is running, a level below its target rises by exactly 1 on every 12th microsecond tick counted from strobe start. The first step comes on the 12th tick after the start cycle.
- R4: A level above its target falls by 2 on each tick (0.5 µs per 25 mA step) and stops at the target. When the strobe request drops, the target is 0.
- R5: In the start cycle the floor is set to the battery value minus (50 + 25 × droop code) mV, saturating at 0. A battery value equal to the floor does not trip the limit.
- R6: A tick on which the battery is below the floor, with droop enabled and blanking low, freezes the ramp. From that tick until the next strobe start no level rises, even if the battery recovers.
- R7: The floor comparison has no effect when droop is disabled or blanking is high.
- R8: While blanking is high, each channel's target becomes the video code, clamped at that channel's ceiling.
- R9: In the fall phase, once all levels are 0, the completion pulse is high for exactly one cycle, and the controller then returns to idle.
- R10: Levels change only on clock edges where the microsecond tick is high.
- R11: A strobe starts whenever the request is high while idle. A request raised during the fall phase is ignored until the completion pulse has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| strobe_req | input | 1 | Flash strobe request, high for the strobe duration |
| blank_in | input | 1 | Blanking: fall back to the video code and suspend droop checks |
| flash_code_wide | input | 6 | Wide-channel target code, 25 mA per LSB |
| flash_code_narrow | input | 5 | Narrow-channel target code, 25 mA per LSB |
| video_code | input | 4 | Fallback level while blanking |
| droop_en | input | 1 | Enables the droop comparison |
| droop_sel | input | 3 | Droop allowance code, 50 mV + 25 mV per step |
| batt_mv | input | 13 | Battery reading in millivolts, unsigned |
| led_level | output | 3x6 | Per-channel current level, 25 mA per unit |
| ramp_done | output | 1 | One-cycle pulse when the fall phase reaches zero |

## Verification
The assertions assume that the microsecond tick is a single-cycle pulse, far rarer than the clock. They also assume that codes, battery and droop settings change only between clock edges. The bench raises the tick for one cycle in every three and drives every input on the falling clock edge. Droop scenarios hold the battery at, just above and just below the captured floor. A blanking window overlaps a battery dip, so that the suspension of the comparison is visible in the levels. A request is re-raised in the middle of a fall.

// File: rtl/flash_ramp_pkg.sv
package flash_ramp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FALL = 2'd2,
      ST_DONE = 2'd3
   } ramp_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int bits_for(input int value);
      return (value < 2) ? 1 : $clog2(value + 1);
   endfunction

endpackage

// File: rtl/flash_ramp_pacer.sv
module flash_ramp_pacer
   import flash_ramp_pkg::*;
#(
   parameter int UP_TICKS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic strobe,
   input  logic all_zero,
   output logic start,
   output logic run,
   output logic up_step,
   output logic done
);

   localparam int CNT_W = (UP_TICKS > 1) ? $clog2(UP_TICKS) : 1;

   if (UP_TICKS < 1) begin : g_bad_ticks
      $error("flash_ramp_pacer: UP_TICKS must be at least 1");
   end

   ramp_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (strobe)   state_d = ST_RUN;
         ST_RUN:  if (!strobe)  state_d = ST_FALL;
         ST_FALL: if (all_zero) state_d = ST_DONE;
         default:               state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign start = (state_q == ST_IDLE) && strobe;
   assign run   = (state_q == ST_RUN) && strobe;
   assign done  = (state_q == ST_DONE);

   if (UP_TICKS == 1) begin : g_every
      assign up_step = run && tick;
   end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(UP_TICKS - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)           cnt_q <= '0;
         else if (start)       cnt_q <= '0;
         else if (run && tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign up_step = run && tick && (cnt_q == LAST);

      a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LAST);
   end

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_fall_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FALL) |=> (state_q == ST_FALL || state_q == ST_DONE));

endmodule

// File: rtl/flash_droop_mon.sv
module flash_droop_mon #(
   parameter int BATT_W  = 13,
   parameter int DSEL_W  = 3,
   parameter int BASE_MV = 50,
   parameter int STEP_MV = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic              tick,
   input  logic              en,
   input  logic              blank,
   input  logic [BATT_W-1:0] batt,
   input  logic [DSEL_W-1:0] dsel,
   output logic              hold_up
);

   localparam int AW     = BATT_W + 1;
   localparam int MAX_MV = BASE_MV + STEP_MV * ((1 << DSEL_W) - 1);

   if (MAX_MV >= (1 << BATT_W)) begin : g_bad_allow
      $error("flash_droop_mon: droop allowance does not fit the battery width");
   end

   logic [AW-1:0]     allow, batt_x, floor_d;
   logic [BATT_W-1:0] floor_q;
   logic              frozen_q, trip;

   always_comb begin
      allow   = AW'(BASE_MV) + AW'(STEP_MV) * AW'(dsel);
      batt_x  = AW'(batt);
      floor_d = (batt_x > allow) ? (batt_x - allow) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     floor_q <= '0;
      else if (start) floor_q <= BATT_W'(floor_d);
   end

   assign trip = run && tick && en && !blank && (batt < floor_q);

   always_ff @(posedge clk) begin
      if (!rst_n)     frozen_q <= 1'b0;
      else if (start) frozen_q <= 1'b0;
      else if (trip)  frozen_q <= 1'b1;
   end

   assign hold_up = frozen_q | trip;

   a_r6_frozen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(frozen_q) && !$past(start)) |-> frozen_q);

   a_r5_floor_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> $stable(floor_q));

endmodule

// File: rtl/flash_ramp_chan.sv
module flash_ramp_chan
   import flash_ramp_pkg::*;
#(
   parameter int LVL_W   = 6,
   parameter int CODE_W  = 6,
   parameter int VID_W   = 4,
   parameter int MAX_LVL = 32,
   parameter int DN_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              up_step,
   input  logic              hold_up,
   input  logic              run,
   input  logic              blank,
   input  logic [CODE_W-1:0] code,
   input  logic [VID_W-1:0]  vid_code,
   output logic [LVL_W-1:0]  lvl
);

   localparam int CW = max_int(max_int(LVL_W, CODE_W), VID_W) + 1;

   if (MAX_LVL >= (1 << LVL_W) || DN_STEP < 1 || DN_STEP > MAX_LVL) begin : g_bad_chan
      $error("flash_ramp_chan: ceiling or down step out of range");
   end

   logic [CW-1:0]    raw, lim, tgt, cur, gap, nxt;
   logic [LVL_W-1:0] lvl_q;

   always_comb begin
      raw = blank ? CW'(vid_code) : CW'(code);
      lim = (raw > CW'(MAX_LVL)) ? CW'(MAX_LVL) : raw;
      tgt = run ? lim : '0;
      cur = CW'(lvl_q);
      gap = cur - tgt;
      nxt = cur;
      if (tick && (cur > tgt)) begin
         nxt = (gap > CW'(DN_STEP)) ? (cur - CW'(DN_STEP)) : tgt;
      end else if (up_step && !hold_up && (cur < tgt)) begin
         nxt = cur + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= LVL_W'(nxt);
   end

   assign lvl = lvl_q;

   a_r2_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= LVL_W'(MAX_LVL));

   a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(lvl_q));

   a_r3_up_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q > $past(lvl_q)) |-> ((lvl_q == $past(lvl_q) + 1'b1) && $past(up_step)));

   a_r4_down_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q < $past(lvl_q)) |-> (($past(lvl_q) - lvl_q) <= LVL_W'(DN_STEP)));

   a_r6_held: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold_up) |-> (lvl_q <= $past(lvl_q)));

endmodule

// File: rtl/flash_ramp_ctrl.sv
module flash_ramp_ctrl
   import flash_ramp_pkg::*;
#(
   parameter int NUM_CH        = 3,
   parameter int WIDE_IDX      = 1,
   parameter int WIDE_W        = 6,
   parameter int NARROW_W      = 5,
   parameter int VID_W         = 4,
   parameter int WIDE_MAX      = 32,
   parameter int NARROW_MAX    = 16,
   parameter int UP_TICKS      = 12,
   parameter int DN_STEP       = 2,
   parameter int BATT_W        = 13,
   parameter int DSEL_W        = 3,
   parameter int DROOP_BASE_MV = 50,
   parameter int DROOP_STEP_MV = 25,
   localparam int LVL_W        = bits_for(max_int(WIDE_MAX, NARROW_MAX))
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          us_tick,
   input  logic                          strobe_req,
   input  logic                          blank_in,
   input  logic [WIDE_W-1:0]             flash_code_wide,
   input  logic [NARROW_W-1:0]           flash_code_narrow,
   input  logic [VID_W-1:0]              video_code,
   input  logic                          droop_en,
   input  logic [DSEL_W-1:0]             droop_sel,
   input  logic [BATT_W-1:0]             batt_mv,
   output logic [NUM_CH-1:0][LVL_W-1:0]  led_level,
   output logic                          ramp_done
);

   if (NUM_CH < 1 || WIDE_IDX < 0 || WIDE_IDX >= NUM_CH) begin : g_bad_top
      $error("flash_ramp_ctrl: channel count or wide index out of range");
   end

   logic [NUM_CH-1:0][LVL_W-1:0] lvl;
   logic start, run, up_step, hold_up, all_zero, done;

   assign all_zero = (lvl == '0);

   flash_ramp_pacer #(
      .UP_TICKS (UP_TICKS)
   ) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (us_tick),
      .strobe   (strobe_req),
      .all_zero (all_zero),
      .start    (start),
      .run      (run),
      .up_step  (up_step),
      .done     (done)
   );

   flash_droop_mon #(
      .BATT_W  (BATT_W),
      .DSEL_W  (DSEL_W),
      .BASE_MV (DROOP_BASE_MV),
      .STEP_MV (DROOP_STEP_MV)
   ) u_droop (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .run     (run),
      .tick    (us_tick),
      .en      (droop_en),
      .blank   (blank_in),
      .batt    (batt_mv),
      .dsel    (droop_sel),
      .hold_up (hold_up)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (c == WIDE_IDX) begin : g_wide
         flash_ramp_chan #(
            .LVL_W   (LVL_W),
            .CODE_W  (WIDE_W),
            .VID_W   (VID_W),
            .MAX_LVL (WIDE_MAX),
            .DN_STEP (DN_STEP)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (us_tick),
            .up_step  (up_step),
            .hold_up  (hold_up),
            .run      (run),
            .blank    (blank_in),
            .code     (flash_code_wide),
            .vid_code (video_code),
            .lvl      (lvl[c])
         );
      end else begin : g_narrow
         flash_ramp_chan #(
            .LVL_W   (LVL_W),
            .CODE_W  (NARROW_W),
            .VID_W   (VID_W),
            .MAX_LVL (NARROW_MAX),
            .DN_STEP (DN_STEP)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (us_tick),
            .up_step  (up_step),
            .hold_up  (hold_up),
            .run      (run),
            .blank    (blank_in),
            .code     (flash_code_narrow),
            .vid_code (video_code),
            .lvl      (lvl[c])
         );
      end
   end

   assign led_level = lvl;
   assign ramp_done = done;

   a_r9_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_done |-> (led_level == '0));

   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $past(!rst_n) |-> (led_level == '0 && !ramp_done));

endmodule

// File: tb/tb_flash_ramp_ctrl.sv
module tb_flash_ramp_ctrl;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic            rst_n = 1'b0, us_tick = 1'b0, strobe = 1'b0, blank = 1'b0, den = 1'b0;
   logic [5:0]      fw = '0;
   logic [4:0]      fn = '0;
   logic [3:0]      vc = '0;
   logic [2:0]      ds = '0;
   logic [12:0]     batt = 13'd3600;
   logic [2:0][5:0] lvl;
   logic            done;

   flash_ramp_ctrl dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .us_tick           (us_tick),
      .strobe_req        (strobe),
      .blank_in          (blank),
      .flash_code_wide   (fw),
      .flash_code_narrow (fn),
      .video_code        (vc),
      .droop_en          (den),
      .droop_sel         (ds),
      .batt_mv           (batt),
      .led_level         (lvl),
      .ramp_done         (done)
   );

   int    checks = 0, errors = 0, ndone = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;

   task automatic chk(input int got, input int exp, input string req, input string what);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   // Behavioural reference: phase 0 idle, 1 running, 2 falling, 3 done pulse
   int m_lvl [3];
   int m_phase, m_ticks, m_floor;
   bit m_frozen;
   int tg, ceil_v, want;
   bit active, dip, climb, zero;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 3; c++) m_lvl[c] = 0;
         m_phase = 0; m_ticks = 0; m_floor = 0; m_frozen = 0;
      end else begin
         active = (m_phase == 1) && strobe;
         zero   = (m_lvl[0] == 0) && (m_lvl[1] == 0) && (m_lvl[2] == 0);
         dip    = active && us_tick && den && !blank && (int'(batt) < m_floor);
         climb  = active && us_tick && (m_ticks == 11) && !m_frozen && !dip;
         for (int c = 0; c < 3; c++) begin
            ceil_v = (c == 1) ? 32 : 16;
            want   = blank ? int'(vc) : ((c == 1) ? int'(fw) : int'(fn));
            tg     = active ? ((want > ceil_v) ? ceil_v : want) : 0;
            if (us_tick && m_lvl[c] > tg)
               m_lvl[c] = (m_lvl[c] - 2 < tg) ? tg : m_lvl[c] - 2;
            else if (climb && m_lvl[c] < tg)
               m_lvl[c] = m_lvl[c] + 1;
         end
         if (dip) m_frozen = 1;
         case (m_phase)
            0: if (strobe) begin
                  m_phase = 1; m_ticks = 0; m_frozen = 0;
                  m_floor = int'(batt) - (50 + 25 * int'(ds));
                  if (m_floor < 0) m_floor = 0;
               end
            1: if (!strobe) m_phase = 2;
               else if (us_tick) m_ticks = (m_ticks == 11) ? 0 : m_ticks + 1;
            2: if (zero) m_phase = 3;
            default: m_phase = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int c = 0; c < 3; c++) chk(int'(lvl[c]), m_lvl[c], cur_req, "cycle level");
         chk(int'(done), (m_phase == 3) ? 1 : 0, cur_req, "cycle done");
         if (done) ndone++;
      end
   end

   task automatic run_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         us_tick = 1'b1;
         @(negedge clk);
         us_tick = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
   endtask

   task automatic begin_strobe();
      strobe = 1'b1;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL R9 watchdog actual hung expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      cur_req = "R1";
      for (int c = 0; c < 3; c++) chk(int'(lvl[c]), 0, "R1", "level in reset");
      chk(int'(done), 0, "R1", "done in reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R3: basic ramp timing
      cur_req = "R3";
      fw = 6'd5; fn = 5'd3;
      begin_strobe();
      run_ticks(11);
      chk(int'(lvl[1]), 0, "R3", "wide level before 12th tick");
      run_ticks(1);
      chk(int'(lvl[1]), 1, "R3", "wide level at 12th tick");
      chk(int'(lvl[0]), 1, "R3", "narrow level at 12th tick");
      run_ticks(100);
      chk(int'(lvl[1]), 5, "R3", "wide level at target");
      chk(int'(lvl[2]), 3, "R3", "narrow level at target");

      // R4: fast fall, R9: done pulse
      cur_req = "R4";
      strobe = 1'b0;
      run_ticks(1);
      chk(int'(lvl[1]), 3, "R4", "wide level after one fall tick");
      chk(int'(lvl[0]), 1, "R4", "narrow level after one fall tick");
      run_ticks(3);
      chk(int'(lvl[1]), 0, "R4", "wide level after fall");
      cur_req = "R9";
      run_ticks(1);
      chk(ndone, 1, "R9", "done pulse count");

      // R2: clamping of large codes
      cur_req = "R2";
      fw = 6'd40; fn = 5'd20;
      begin_strobe();
      run_ticks(400);
      chk(int'(lvl[1]), 32, "R2", "wide ceiling");
      chk(int'(lvl[0]), 16, "R2", "narrow ceiling ch0");
      chk(int'(lvl[2]), 16, "R2", "narrow ceiling ch2");
      cur_req = "R4";
      strobe = 1'b0;
      run_ticks(8);
      chk(int'(lvl[1]), 16, "R4", "wide level after 8 fall ticks");
      chk(int'(lvl[0]), 0, "R4", "narrow level after 8 fall ticks");
      run_ticks(9);
      chk(ndone, 2, "R9", "done after clamp run");

      // R6: droop freeze
      cur_req = "R6";
      fw = 6'd10; fn = 5'd10; den = 1'b1; ds = 3'd2; batt = 13'd3600;
      begin_strobe();
      run_ticks(40);
      chk(int'(lvl[1]), 3, "R6", "level before dip");
      batt = 13'd3400;
      run_ticks(100);
      chk(int'(lvl[1]), 3, "R6", "level held after dip");
      batt = 13'd3600;
      run_ticks(50);
      chk(int'(lvl[1]), 3, "R6", "level held after recovery");
      strobe = 1'b0;
      run_ticks(5);

      // R7: droop disabled
      cur_req = "R7";
      den = 1'b0;
      begin_strobe();
      run_ticks(40);
      batt = 13'd3400;
      run_ticks(100);
      chk(int'(lvl[1]), 10, "R7", "disabled droop keeps ramping");
      strobe = 1'b0; batt = 13'd3600;
      run_ticks(8);

      // R8: blanking, R7: blanking suspends droop
      cur_req = "R8";
      den = 1'b1; ds = 3'd2; fw = 6'd12; fn = 5'd8; vc = 4'd4;
      begin_strobe();
      run_ticks(150);
      chk(int'(lvl[1]), 12, "R8", "wide level before blank");
      chk(int'(lvl[0]), 8, "R8", "narrow level before blank");
      blank = 1'b1;
      run_ticks(4);
      chk(int'(lvl[1]), 4, "R8", "wide level at video code");
      chk(int'(lvl[0]), 4, "R8", "narrow level at video code");
      cur_req = "R7";
      batt = 13'd3000;
      run_ticks(20);
      batt = 13'd3600; blank = 1'b0;
      run_ticks(100);
      chk(int'(lvl[1]), 12, "R7", "blank dip did not freeze");
      chk(int'(lvl[0]), 8, "R7", "narrow back at target");

      // R11: request during fall is ignored, then restart
      cur_req = "R11";
      strobe = 1'b0;
      run_ticks(2);
      chk(int'(lvl[1]), 8, "R11", "wide level mid fall");
      strobe = 1'b1;
      run_ticks(2);
      chk(int'(lvl[1]), 4, "R11", "fall continues with request high");
      run_ticks(2);
      chk(int'(lvl[1]), 0, "R11", "fall reaches zero");
      chk(ndone, 5, "R11", "done before restart");
      run_ticks(13);
      chk(int'(lvl[1]), 1, "R11", "new strobe after done");
      strobe = 1'b0;
      run_ticks(3);

      // R5: floor boundary
      cur_req = "R5";
      ds = 3'd0; batt = 13'd3600;
      begin_strobe();
      run_ticks(30);
      batt = 13'd3550;
      run_ticks(30);
      chk(int'(lvl[1]), 5, "R5", "battery equal to floor no trip");
      batt = 13'd3549;
      run_ticks(30);
      chk(int'(lvl[1]), 5, "R5", "battery below floor trips");
      strobe = 1'b0; batt = 13'd3600;
      run_ticks(5);

      // R5: saturating floor; R10: no change without tick
      ds = 3'd7; batt = 13'd30;
      begin_strobe();
      run_ticks(2);
      batt = 13'd0;
      run_ticks(40);
      chk(int'(lvl[1]), 3, "R5", "floor saturated at zero");
      cur_req = "R10";
      strobe = 1'b0;
      repeat (20) @(negedge clk);
      chk(int'(lvl[1]), 3, "R10", "no change without tick");
      run_ticks(3);
      chk(int'(lvl[1]), 0, "R10", "fall resumes on ticks");

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule